// File: doc/BRIEF.md
# Zero-Page Bit-Clear Sequencer

This block is a small multi-cycle execution engine for an 8-bit processor. It runs only the eight single-bit clear instructions that work on zero-page memory. Each instruction is two bytes long: an opcode, then a one-byte zero-page address. The block reads the addressed byte, clears the one bit that the opcode names, and writes the byte back. Every other bit of the byte keeps its value.

The block has one synchronous memory port. Read data returns one cycle after the address is presented. The port also carries write data and a write enable. The block exposes its 16-bit program counter and a running cycle counter so that timing can be checked. Any opcode outside the supported set raises an illegal-opcode flag and stops the sequencer until the next reset.

Top module: `bitclr_seq`

## Requirements
- R1: An opcode is supported when its low nibble is 0x7 and bit 7 is 0, which gives the eight values 0x07, 0x17, 0x27, 0x37, 0x47, 0x57, 0x67 and 0x77. Opcode bits 6:4 give the index of the bit to clear.
- R2: The byte written back equals the byte read from the target, ANDed with a mask that is zero only at the selected bit. For example, 0xFF with bit 7 cleared becomes 0x7F, and 0xA5 with bit 1 cleared stays 0xA5.
- R3: The target address has a high byte of 0x00. Its low byte is the operand byte that follows the opcode. No other memory location is written.
- R4: Each completed instruction advances the program counter by exactly 2. One instruction started at 0x0000 leaves the counter at 0x0002.
- R5: Each instruction takes exactly five clock cycles, and the cycle counter rises by 5 per instruction.
- R6: The five bus cycles run in this order: opcode read at PC, operand read at PC+1, target read, a second (dummy) read of the target, then the write to the target. Write enable is high only in the fifth cycle.
- R7: Read data is taken one cycle after its address is presented. The operand is captured in the cycle after the operand request, and the target byte in the cycle after the target request.
- R8: An unsupported opcode sets the illegal-opcode output and halts the sequencer. While halted there are no writes, and the program counter and the cycle counter stay frozen until reset.
- R9: Reset sets the program counter to 0x0000, clears the cycle counter, clears the illegal flag and write enable, and returns the sequencer to opcode fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mem_addr | output | 16 | Memory address for the current bus cycle |
| mem_rdata | input | 8 | Read data; returns one cycle after the address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable |
| pc | output | 16 | Program counter |
| cycle_cnt | output | 32 | Count of executed clock cycles since reset |
| illegal_op | output | 1 | Sticky flag: an unsupported opcode was fetched |

## Verification
The assertions assume that memory returns, one cycle later, the byte that was stored at the requested address. The write-back property compares the written byte with the read data from the cycle before the write. That comparison holds only if memory behaves this way. The bench's memory model follows this one-cycle latency, and no other agent writes into memory while an instruction is in progress. Programs sit at low addresses, and targets are placed away from the program bytes, so a write never changes an opcode that has yet to be fetched.

// File: rtl/bitclr_pkg.sv
`timescale 1ns/1ps
package bitclr_pkg;
  typedef enum logic [2:0] {
    ST_OPC  = 3'd0,
    ST_OPR  = 3'd1,
    ST_RD   = 3'd2,
    ST_GAP  = 3'd3,
    ST_WR   = 3'd4,
    ST_HALT = 3'd5
  } seq_state_e;

  localparam int unsigned OPC_FIELD_LO = 4;
  localparam logic [3:0]  OPC_LOW_NIB  = 4'h7;
endpackage

// File: rtl/bitclr_rst_sync.sv
`timescale 1ns/1ps
module bitclr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bitclr_decode.sv
`timescale 1ns/1ps
module bitclr_decode import bitclr_pkg::*; #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] opcode,
  output logic              op_ok,
  output logic [DATA_W-1:0] keep_mask
);
  localparam int unsigned IDX_W  = $clog2(DATA_W);
  localparam int unsigned FLD_LO = OPC_FIELD_LO;
  localparam int unsigned FLD_HI = FLD_LO + IDX_W - 1;

  logic [IDX_W-1:0] bit_idx;
  logic             upper_clear;

  assign bit_idx = opcode[FLD_HI:FLD_LO];

  generate
    if (FLD_HI + 1 <= DATA_W - 1) begin : g_upper
      assign upper_clear = (opcode[DATA_W-1:FLD_HI+1] == '0);
    end else begin : g_no_upper
      assign upper_clear = 1'b1;
    end
  endgenerate

  assign op_ok = upper_clear && (opcode[3:0] == OPC_LOW_NIB);

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign keep_mask[i] = (bit_idx != IDX_W'(i));
    end
  endgenerate
endmodule

// File: rtl/bitclr_fsm.sv
`timescale 1ns/1ps
module bitclr_fsm import bitclr_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_ok,
  output seq_state_e state
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OPC:  state_d = ST_OPR;
      ST_OPR:  state_d = op_ok ? ST_RD : ST_HALT;
      ST_RD:   state_d = ST_GAP;
      ST_GAP:  state_d = ST_WR;
      ST_WR:   state_d = ST_OPC;
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OPC;
    else        state_q <= state_d;
  end

  assign state = state_q;

  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT) |=> (state_q == ST_HALT));
endmodule

// File: rtl/bitclr_datapath.sv
`timescale 1ns/1ps
module bitclr_datapath import bitclr_pkg::*; #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              op_ok,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] pc,
  output logic [CNT_W-1:0]  cycle_cnt,
  output logic              illegal_op
);
  localparam int unsigned PAGE_W  = ADDR_W - DATA_W;
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(2);

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [DATA_W-1:0] opc_q, zp_q, dat_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ill_q;
  logic              pc_en, opc_en, zp_en, dat_en, cnt_en, ill_en;
  logic [DATA_W-1:0] dec_in, keep_mask;
  logic [ADDR_W-1:0] zp_addr, addr_d;

  // Decode the fresh opcode during operand fetch, the held one afterwards
  assign dec_in = (state == ST_OPR) ? mem_rdata : opc_q;

  bitclr_decode #(.DATA_W(DATA_W)) u_decode (
    .opcode    (dec_in),
    .op_ok     (op_ok),
    .keep_mask (keep_mask)
  );

  // Clock enables
  assign opc_en = (state == ST_OPR);
  assign zp_en  = (state == ST_RD);
  assign dat_en = (state == ST_GAP);
  assign pc_en  = (state == ST_WR);
  assign cnt_en = (state != ST_HALT);
  assign ill_en = (state == ST_OPR) && !op_ok;

  assign pc_d  = pc_q + PC_STEP;
  assign cnt_d = cnt_q + CNT_W'(1);

  assign zp_addr = {{PAGE_W{1'b0}}, zp_q};

  always_comb begin
    unique case (state)
      ST_OPC:  addr_d = pc_q;
      ST_OPR:  addr_d = pc_q + ADDR_W'(1);
      ST_RD:   addr_d = {{PAGE_W{1'b0}}, mem_rdata};
      ST_GAP:  addr_d = zp_addr;
      ST_WR:   addr_d = zp_addr;
      default: addr_d = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      opc_q <= '0;
      zp_q  <= '0;
      dat_q <= '0;
      cnt_q <= '0;
      ill_q <= 1'b0;
    end else begin
      if (pc_en)  pc_q  <= pc_d;
      if (opc_en) opc_q <= mem_rdata;
      if (zp_en)  zp_q  <= mem_rdata;
      if (dat_en) dat_q <= mem_rdata;
      if (cnt_en) cnt_q <= cnt_d;
      if (ill_en) ill_q <= 1'b1;
    end
  end

  assign mem_addr   = addr_d;
  assign mem_we     = (state == ST_WR);
  assign mem_wdata  = dat_q & keep_mask;
  assign pc         = pc_q;
  assign cycle_cnt  = cnt_q;
  assign illegal_op = ill_q;

  a_r2_keep_other_bits: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (((mem_wdata ^ $past(mem_rdata)) & keep_mask) == '0));

  a_r2_one_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(~keep_mask) == 1) && ((mem_wdata & ~keep_mask) == '0));

  a_r3_zero_page: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[ADDR_W-1:DATA_W] == '0) && (mem_addr == $past(mem_addr)));

  a_r4_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_q != $past(pc_q)) |-> (pc_q == $past(pc_q) + PC_STEP));

  a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)));

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ill_q |=> ill_q && $stable(pc_q) && $stable(cnt_q) && !mem_we);
endmodule

// File: rtl/bitclr_seq.sv
`timescale 1ns/1ps
module bitclr_seq import bitclr_pkg::*; #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] pc,
  output logic [CNT_W-1:0]  cycle_cnt,
  output logic              illegal_op
);
  localparam int unsigned INSTR_CYCLES = 5;

  logic       rst_i_n;
  logic       op_ok;
  seq_state_e state;

  bitclr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  bitclr_fsm u_fsm (
    .clk   (clk),
    .rst_n (rst_i_n),
    .op_ok (op_ok),
    .state (state)
  );

  bitclr_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .state      (state),
    .mem_rdata  (mem_rdata),
    .op_ok      (op_ok),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .pc         (pc),
    .cycle_cnt  (cycle_cnt),
    .illegal_op (illegal_op)
  );

  a_r6_single_write: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_we |=> !mem_we);

  a_r5_five_per_instr: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_we |=> ((cycle_cnt % CNT_W'(INSTR_CYCLES)) == '0));

  a_r6_fetch_after_write: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_we |=> (mem_addr == pc));
endmodule

// File: tb/bitclr_seq_bench.sv
`timescale 1ns/1ps
module bitclr_seq_bench;
  logic        clk;
  logic        rst_n;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [15:0] pc;
  logic [31:0] cycle_cnt;
  logic        illegal_op;

  int n_chk;
  int n_bad;
  int we_seen;
  logic [7:0] mem [0:1023];

  bitclr_seq u_bitclr_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .pc         (pc),
    .cycle_cnt  (cycle_cnt),
    .illegal_op (illegal_op)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr[9:0]];
    if (mem_we) begin
      mem[mem_addr[9:0]] <= mem_wdata;
      we_seen <= we_seen + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    we_seen = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic release_reset();
    rst_n = 1'b1;
  endtask

  task automatic wait_pc(input logic [15:0] target);
    for (int i = 0; i < 400; i++) begin
      if (pc == target) break;
      @(negedge clk);
    end
  endtask

  // R9: reset values, then R9 again after a halt
  task automatic t_reset();
    hold_reset();
    chk("R9 pc", 32'(pc), 32'h0);
    chk("R9 cnt", cycle_cnt, 32'h0);
    chk("R9 illegal", 32'(illegal_op), 32'h0);
    chk("R9 we", 32'(mem_we), 32'h0);
    chk("R9 fetch addr", 32'(mem_addr), 32'h0);
  endtask

  // R1 R2 R4 R5: each supported opcode clears its own bit
  task automatic t_one(input int b, input logic [7:0] zp, input logic [7:0] pat);
    logic [7:0] exp;
    hold_reset();
    mem[0] = 8'h07 | 8'(b << 4);
    mem[1] = zp;
    mem[zp] = pat;
    mem[zp + 1] = 8'h3C;
    exp = pat & ~(8'h01 << b);
    release_reset();
    wait_pc(16'h0002);
    chk($sformatf("R4 pc after bit %0d", b), 32'(pc), 32'h2);
    chk($sformatf("R5 cnt after bit %0d", b), cycle_cnt, 32'd5);
    chk($sformatf("R2 byte bit %0d pat %0h", b, pat), 32'(mem[zp]), 32'(exp));
    chk($sformatf("R3 neighbour untouched bit %0d", b), 32'(mem[zp + 1]), 32'h3C);
    chk("R3 single write", 32'(we_seen), 32'd1);
  endtask

  // R6 R7 R3: bus order cycle by cycle
  task automatic t_bus_order();
    hold_reset();
    mem[0] = 8'h47;
    mem[1] = 8'h43;
    mem[8'h43] = 8'hFF;
    release_reset();
    for (int i = 0; i < 20; i++) begin
      if (cycle_cnt == 32'd1) break;
      @(negedge clk);
    end
    chk("R6 operand addr", 32'(mem_addr), 32'h0001);
    chk("R6 no we c2", 32'(mem_we), 32'h0);
    @(negedge clk);
    chk("R7 R3 target read addr", 32'(mem_addr), 32'h0043);
    chk("R6 no we c3", 32'(mem_we), 32'h0);
    @(negedge clk);
    chk("R6 dummy addr", 32'(mem_addr), 32'h0043);
    chk("R6 no we c4", 32'(mem_we), 32'h0);
    @(negedge clk);
    chk("R6 write addr", 32'(mem_addr), 32'h0043);
    chk("R6 we c5", 32'(mem_we), 32'h1);
    chk("R7 wdata", 32'(mem_wdata), 32'hEF);
    @(negedge clk);
    chk("R6 next fetch addr", 32'(mem_addr), 32'h0002);
    chk("R6 no we after", 32'(mem_we), 32'h0);
    chk("R5 cnt", cycle_cnt, 32'd5);
  endtask

  // R4 R5 R2: three back-to-back instructions
  task automatic t_sequence();
    hold_reset();
    mem[0] = 8'h17; mem[1] = 8'h50;
    mem[2] = 8'h57; mem[3] = 8'h51;
    mem[4] = 8'h77; mem[5] = 8'h50;
    mem[8'h50] = 8'hFF;
    mem[8'h51] = 8'hFF;
    release_reset();
    wait_pc(16'h0006);
    chk("R4 pc after three", 32'(pc), 32'h6);
    chk("R5 cnt after three", cycle_cnt, 32'd15);
    chk("R2 seq byte 0x50", 32'(mem[8'h50]), 32'h7D);
    chk("R2 seq byte 0x51", 32'(mem[8'h51]), 32'hDF);
  endtask

  // R8 R1: unsupported opcode halts; R9 reset clears the flag
  task automatic t_illegal(input logic [7:0] opc);
    logic [31:0] cnt_snap;
    hold_reset();
    mem[0] = opc;
    mem[1] = 8'h48;
    mem[8'h48] = 8'hFF;
    release_reset();
    repeat (10) @(negedge clk);
    cnt_snap = cycle_cnt;
    chk($sformatf("R8 R1 illegal flag op %0h", opc), 32'(illegal_op), 32'h1);
    repeat (20) @(negedge clk);
    chk($sformatf("R8 pc frozen op %0h", opc), 32'(pc), 32'h0);
    chk($sformatf("R8 cnt frozen op %0h", opc), cycle_cnt, cnt_snap);
    chk($sformatf("R8 no write op %0h", opc), 32'(we_seen), 32'd0);
    chk($sformatf("R8 target kept op %0h", opc), 32'(mem[8'h48]), 32'hFF);
    hold_reset();
    chk("R9 illegal cleared", 32'(illegal_op), 32'h0);
  endtask

  // R8: a supported instruction completes before a bad one halts
  task automatic t_illegal_after();
    hold_reset();
    mem[0] = 8'h27; mem[1] = 8'h60;
    mem[2] = 8'hFF; mem[3] = 8'h61;
    mem[8'h60] = 8'hFF;
    release_reset();
    repeat (30) @(negedge clk);
    chk("R8 illegal after good", 32'(illegal_op), 32'h1);
    chk("R8 pc after good", 32'(pc), 32'h2);
    chk("R2 good byte", 32'(mem[8'h60]), 32'hFB);
    chk("R8 one write", 32'(we_seen), 32'd1);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    t_reset();
    for (int b = 0; b < 8; b++) t_one(b, 8'h43, 8'hFF);
    t_one(0, 8'h70, 8'hA5);
    t_one(1, 8'h70, 8'hA5);
    t_one(7, 8'hC0, 8'h00);
    t_one(7, 8'hC0, 8'h80);
    t_bus_order();
    t_sequence();
    t_illegal(8'h87);
    t_illegal(8'h05);
    t_illegal(8'hF7);
    t_illegal_after();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule